// File: doc/BRIEF.md
# Register LIFO Stack with Full and Empty Flags

This block is a last-in, first-out store of 64 words held in a register array, steered by a 6-bit stack pointer. A push request writes one word onto the stack; a pop request returns the most recent word on a registered data output, which is marked by a one-cycle valid strobe. Two flags report whether the stack holds nothing or holds all 64 words.

The pointer always addresses the current top word. A push advances the pointer by one, wrapping at 64, and stores the word at the new pointer value. A pop reads the word at the current pointer and then moves the pointer back by one, wrapping at 64. Both flags are found by the pointer landing on zero. The first word therefore sits at address 1 and the 64th word at address 0.

A small state machine tracks occupancy. It has three states. `ST_EMPTY` means no words are held. `ST_PARTIAL` means between 1 and 63 words are held. `ST_FULL` means 64 words are held. The transitions are:
- `ST_EMPTY` to `ST_PARTIAL` on an accepted push.
- `ST_PARTIAL` to `ST_FULL` on a push that wraps the pointer to zero.
- `ST_PARTIAL` to `ST_EMPTY` on a pop that leaves the pointer at zero.
- `ST_FULL` to `ST_PARTIAL` on an accepted pop.

Every other case holds the current state: an idle cycle, a rejected request, or a request with push and pop both asserted.

Top module: `reg_stack`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sp_o` is 0, `empty_o` is 1, `full_o` is 0, and both `pop_valid_o` and `err_o` are 0.
- R2: An accepted push (push_i=1, pop_i=0, not full) sets `sp_o` to the old value plus 1, modulo 64, on the next cycle, and stores `push_data_i` at that new address.
- R3: An accepted push whose new pointer is 0 sets `full_o`. Every accepted push clears `empty_o`.
- R4: An accepted pop (pop_i=1, push_i=0, not empty) places the word at the current pointer on `pop_data_o` with `pop_valid_o`=1 in the next cycle. It sets `sp_o` to the old value minus 1, modulo 64.
- R5: An accepted pop whose new pointer is 0 sets `empty_o`. Every accepted pop clears `full_o`.
- R6: Words come back in reverse order of their pushes. The stack holds exactly 64 words, and the 64th word is stored at address 0.
- R7: A push while `full_o`=1 leaves the pointer, the flags and the contents unchanged. It raises `err_o` for the single following cycle.
- R8: A pop while `empty_o`=1 leaves the pointer and the flags unchanged and gives no valid strobe. It raises `err_o` for the single following cycle.
- R9: When push_i and pop_i are both 1 in the same cycle, nothing changes: no write, no read strobe and no error.
- R10: `pop_valid_o` is 1 only in the cycle directly after an accepted pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| push_data_i | input | DATA_W (8) | Word to push |
| pop_data_o | output | DATA_W (8) | Registered popped word |
| pop_valid_o | output | 1 | Popped word valid strobe |
| sp_o | output | ADDR_W (6) | Stack pointer (address of the top word) |
| full_o | output | 1 | 64 words held |
| empty_o | output | 1 | No words held |
| err_o | output | 1 | One-cycle pulse after a rejected push or pop |

## Verification
The bench fills the stack to exactly 64 words and pushes once more. A design that sets full one word early, or that lets the extra push overwrite address 1, shows a wrong pointer, a wrong flag or a corrupted word when the stack is later drained in reverse order. It drains the stack through the last word and pops once more. An off-by-one in the empty test would either lose the word at address 1 or return a stale word with a valid strobe. Push and pop asserted together are applied both in the middle of the stack and at each boundary, where a design that prioritised one request would move the pointer. A long stretch of mixed random traffic is compared every cycle against a queue model, to catch wrap-around errors in the pointer arithmetic.

// File: rtl/stk_pkg.sv
package stk_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } stk_state_e;
endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_i,
    input  logic              dec_i,
    output logic [ADDR_W-1:0] sp_o,
    output logic [ADDR_W-1:0] sp_inc_o,
    output logic [ADDR_W-1:0] sp_dec_o
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] sp_q;

    // Modulo arithmetic comes free from the fixed width.
    assign sp_inc_o = sp_q + ONE;
    assign sp_dec_o = sp_q - ONE;
    assign sp_o     = sp_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     sp_q <= '0;
        else if (inc_i) sp_q <= sp_inc_o;
        else if (dec_i) sp_q <= sp_dec_o;
    end

    a_r2_ptr_advances: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |=> sp_o == $past(sp_o) + ONE);
    a_r4_ptr_retreats: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |=> sp_o == $past(sp_o) - ONE);
    a_r9_single_op: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc_i && dec_i));
endmodule

// File: rtl/stk_mem.sv
module stk_mem #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i) cells[wr_addr_i] <= wr_data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_o  <= '0;
            rd_valid_o <= 1'b0;
        end else begin
            rd_valid_o <= rd_en_i;
            if (rd_en_i) rd_data_o <= cells[rd_addr_i];
        end
    end

    a_r4_valid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> rd_valid_o);
    a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> !rd_valid_o);
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
    import stk_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [ADDR_W-1:0] sp_i,
    input  logic [ADDR_W-1:0] sp_inc_i,
    input  logic [ADDR_W-1:0] sp_dec_i,
    output logic              do_push_o,
    output logic              do_pop_o,
    output logic              full_o,
    output logic              empty_o,
    output logic              err_o
);
    stk_state_e state_q, state_d;
    logic       err_q;
    logic       only_push, only_pop, reject;

    assign only_push = push_i && !pop_i;
    assign only_pop  = pop_i && !push_i;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= reject;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (only_push)
                    state_d = (sp_inc_i == '0) ? ST_FULL : ST_PARTIAL;
            end
            ST_PARTIAL: begin
                if (only_push && sp_inc_i == '0)
                    state_d = ST_FULL;
                else if (only_pop && sp_dec_i == '0)
                    state_d = ST_EMPTY;
            end
            ST_FULL: begin
                if (only_pop)
                    state_d = (sp_dec_i == '0) ? ST_EMPTY : ST_PARTIAL;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // Outputs.
    always_comb begin
        do_push_o = 1'b0;
        do_pop_o  = 1'b0;
        reject    = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                do_push_o = only_push;
                reject    = only_pop;
            end
            ST_PARTIAL: begin
                do_push_o = only_push;
                do_pop_o  = only_pop;
            end
            ST_FULL: begin
                do_pop_o = only_pop;
                reject   = only_push;
            end
            default: ;
        endcase
        full_o  = (state_q == ST_FULL);
        empty_o = (state_q == ST_EMPTY);
        err_o   = err_q;
    end

    a_r3_full_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> sp_i == '0);
    a_r5_empty_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o |-> sp_i == '0);
    a_r7_push_full_err: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && full_o) |=> (err_o && full_o));
    a_r8_pop_empty_err: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && empty_o) |=> (err_o && empty_o));
    a_r9_both_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> (!err_o && state_q == $past(state_q)));
endmodule

// File: rtl/reg_stack.sv
module reg_stack #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] push_data_i,
    output logic [DATA_W-1:0] pop_data_o,
    output logic              pop_valid_o,
    output logic [ADDR_W-1:0] sp_o,
    output logic              full_o,
    output logic              empty_o,
    output logic              err_o
);
    logic              do_push, do_pop;
    logic [ADDR_W-1:0] sp, sp_inc, sp_dec;

    stk_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (push_i),
        .pop_i     (pop_i),
        .sp_i      (sp),
        .sp_inc_i  (sp_inc),
        .sp_dec_i  (sp_dec),
        .do_push_o (do_push),
        .do_pop_o  (do_pop),
        .full_o    (full_o),
        .empty_o   (empty_o),
        .err_o     (err_o)
    );

    stk_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_i    (do_push),
        .dec_i    (do_pop),
        .sp_o     (sp),
        .sp_inc_o (sp_inc),
        .sp_dec_o (sp_dec)
    );

    stk_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (do_push),
        .wr_addr_i  (sp_inc),
        .wr_data_i  (push_data_i),
        .rd_en_i    (do_pop),
        .rd_addr_i  (sp),
        .rd_data_o  (pop_data_o),
        .rd_valid_o (pop_valid_o)
    );

    assign sp_o = sp;
endmodule

// File: tb/test_reg_stack.sv
module test_reg_stack;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 6;
    localparam int DEPTH  = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              push_i = 1'b0;
    logic              pop_i = 1'b0;
    logic [DATA_W-1:0] push_data_i = '0;
    logic [DATA_W-1:0] pop_data_o;
    logic              pop_valid_o;
    logic [ADDR_W-1:0] sp_o;
    logic              full_o, empty_o, err_o;

    int n_checks = 0;
    int n_fail   = 0;

    logic [DATA_W-1:0] model_q[$];
    int                exp_valid = 0;
    int                exp_err   = 0;
    int                exp_data  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reg_stack #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_reg_stack (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
        .push_data_i(push_data_i), .pop_data_o(pop_data_o),
        .pop_valid_o(pop_valid_o), .sp_o(sp_o), .full_o(full_o),
        .empty_o(empty_o), .err_o(err_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Compare every output against the queue model.
    task automatic compare_all();
        int n = model_q.size();
        check("R2 sp", int'(sp_o), n % DEPTH);
        check("R3 full", int'(full_o), (n == DEPTH) ? 1 : 0);
        check("R5 empty", int'(empty_o), (n == 0) ? 1 : 0);
        check("R10 valid", int'(pop_valid_o), exp_valid);
        check("R7 R8 err", int'(err_o), exp_err);
        if (exp_valid != 0) check("R4 R6 data", int'(pop_data_o), exp_data);
    endtask

    task automatic cyc(input logic p, input logic o, input logic [DATA_W-1:0] d);
        int n;
        push_i = p; pop_i = o; push_data_i = d;
        @(posedge clk);
        n = model_q.size();
        exp_valid = 0;
        exp_err   = 0;
        if (p && !o) begin
            if (n == DEPTH) exp_err = 1;
            else model_q.push_back(d);
        end else if (o && !p) begin
            if (n == 0) exp_err = 1;
            else begin
                exp_data  = int'(model_q.pop_back());
                exp_valid = 1;
            end
        end
        @(negedge clk);
        push_i = 1'b0; pop_i = 1'b0;
        compare_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: got 0 expected 1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values while reset is held
        check("R1 sp", int'(sp_o), 0);
        check("R1 empty", int'(empty_o), 1);
        check("R1 full", int'(full_o), 0);
        check("R1 valid", int'(pop_valid_o), 0);
        check("R1 err", int'(err_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();

        // R8: pop on empty stack
        cyc(1'b0, 1'b1, 8'h00);
        cyc(1'b0, 1'b0, 8'h00);
        // R9: both at empty boundary
        cyc(1'b1, 1'b1, 8'hAA);
        // R2 / R4: a few pushes and pops
        for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 8'(8'h10 + i));
        cyc(1'b1, 1'b1, 8'h77);
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 8'h00);
        // R5: drain, then extra pop (R8)
        cyc(1'b0, 1'b1, 8'h00);
        cyc(1'b0, 1'b1, 8'h00);
        cyc(1'b0, 1'b1, 8'h00);
        // R6 / R3: fill to 64 words
        for (int i = 0; i < DEPTH; i++) cyc(1'b1, 1'b0, 8'(8'hC0 ^ (i * 7)));
        check("R3 full after 64", int'(full_o), 1);
        // R7: push when full, twice
        cyc(1'b1, 1'b0, 8'h55);
        cyc(1'b1, 1'b0, 8'h66);
        cyc(1'b0, 1'b0, 8'h00);
        // R9: both at full boundary
        cyc(1'b1, 1'b1, 8'h99);
        // R6: drain all 64 in reverse order
        for (int i = 0; i < DEPTH; i++) cyc(1'b0, 1'b1, 8'h00);
        check("R5 empty after drain", int'(empty_o), 1);
        // Mixed random traffic with wrap-around
        for (int i = 0; i < 3000; i++) begin
            logic p, o;
            int r = int'($urandom_range(0, 9));
            p = (r < 5);
            o = (r >= 4 && r < 9);
            cyc(p, o, 8'($urandom));
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule